// File: doc/BRIEF.md
# Delta-Sigma Converter Frame Reader

This block sits on the host side of a three-wire serial link to a delta-sigma converter. On a start request it pulls chip select low and then waits. While a conversion is still running, the converter holds its data line high. The reader begins clocking only after the line falls, because that low level means a result is ready. It then drives 32 serial clock pulses, with the clock idling low, and captures one data bit on each rising edge, most significant bit first. After the last falling edge it releases chip select.

The captured word is decoded as follows:
- Bit 31 is the end-of-conversion bit and bit 30 is a fixed filler bit. Both must read 0.
- Bit 29 is a sign bit.
- Bits 28..5 hold a 24-bit two's complement result.
- Bits 4..0 are sub-LSB bits that sit below the 24-bit level.

The pair formed by bit 29 and bit 28 carries the range status. When both are 1 the input is over range, and when both are 0 it is under range. In either case the result is clamped to the matching extreme of the 24-bit range. A frame that passes the checks is announced by a one-cycle valid strobe. A frame that fails them gives a one-cycle error strobe instead, and no valid strobe.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, cs_no is 1, sck_o is 0, and valid_o and err_o are 0.
- R2: After start_i is accepted, cs_no goes low. sck_o stays low for as long as sdo_i reads high, and clocking begins only after sdo_i is sampled low.
- R3: Each frame has exactly 32 rising edges on sck_o. Each sck_o level lasts HALF_DIV clock cycles, so rising edges are 2*HALF_DIV cycles apart. sck_o is low whenever cs_no is high.
- R4: For an in-range frame, result_o equals captured bits 28..5, where captured bit 31 is the first bit and bit 0 is the 32nd.
- R5: sub_lsb_o equals captured bits 4..0.
- R6: When bits 29 and 28 are both 1, over_o is 1, under_o is 0, and result_o is 0x7FFFFF.
- R7: When bits 29 and 28 are both 0, under_o is 1, over_o is 0, and result_o is 0x800000.
- R8: When bit 31 or bit 30 is 1, err_o pulses for one cycle and valid_o stays 0.
- R9: cs_no stays low for the whole frame. It rises on the same clock edge as the 32nd falling edge of sck_o. valid_o is a single-cycle pulse in the cycle that follows that edge.
- R10: A start_i that arrives while a frame is in progress is ignored. No second frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to read one frame |
| sdo_i | input | 1 | Serial data from the converter |
| cs_no | output | 1 | Active-low chip select |
| sck_o | output | 1 | Serial clock, idles low |
| result_o | output | 24 | Two's complement result, clamped when out of range |
| sub_lsb_o | output | 5 | Bits below the result LSB |
| over_o | output | 1 | Input above plus full scale |
| under_o | output | 1 | Input below minus full scale |
| valid_o | output | 1 | One-cycle strobe for a good frame |
| err_o | output | 1 | One-cycle strobe for a frame with a bad header |

## Verification
The bench holds sdo_i high for a random number of cycles before signalling end of conversion. A reader that starts clocking without waiting for that low level would show rising edges before the low level, and would capture a shifted frame. Directed frames cover:
- zero and minus one LSB, where a reader that misreads the sign bit returns a wrong value;
- both clamp codes, where a design that copies the bits gives the wrong magnitude;
- a set header bit 31 or bit 30, where a reader that skips the header check still raises valid.

A start pulse is also sent during a transfer, to catch a second frame that should not begin.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int RES_W   = 24;
  localparam int SUB_W   = 5;
  localparam int FRAME_W = RES_W + SUB_W + 3;
  localparam int EOC_POS = FRAME_W - 1;
  localparam int DMY_POS = FRAME_W - 2;
  localparam int SIG_POS = FRAME_W - 3;
  localparam int MSB_POS = FRAME_W - 4;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SHIFT} rd_state_e;

  typedef struct packed {
    logic [RES_W-1:0] value;
    logic [SUB_W-1:0] sub;
    logic             over;
    logic             under;
    logic             bad;
  } frame_dec_t;
endpackage

// File: rtl/adc_sck_gen.sv
module adc_sck_gen #(
  parameter int HALF_DIV = 2  // must be >= 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick   = run_i && (cnt_q == CW'(HALF_DIV - 1));
  assign rise_o = tick && !sck_o;
  assign fall_o = tick && sck_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_o <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      sck_o <= ~sck_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_SCK_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !sck_o); // R3
endmodule

// File: rtl/adc_bit_shifter.sv
module adc_bit_shifter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] frame_o,
  output logic         full_o
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q;

  assign full_o = (cnt_q == CW'(W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_o <= '0;
      cnt_q   <= '0;
    end else if (clear_i) begin
      frame_o <= '0;
      cnt_q   <= '0;
    end else if (shift_i) begin
      frame_o <= {frame_o[W-2:0], bit_i};
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> !full_o); // R3
endmodule

// File: rtl/adc_frame_decode.sv
module adc_frame_decode
  import adc_rd_pkg::*;
(
  input  logic [FRAME_W-1:0] frame_i,
  output frame_dec_t         dec_o
);
  logic sig_b, msb_b;

  assign sig_b = frame_i[SIG_POS];
  assign msb_b = frame_i[MSB_POS];

  always_comb begin
    dec_o.over  = sig_b && msb_b;
    dec_o.under = !sig_b && !msb_b;
    dec_o.bad   = frame_i[EOC_POS] || frame_i[DMY_POS];
    dec_o.sub   = frame_i[SUB_W-1:0];
    if (dec_o.over)
      dec_o.value = {1'b0, {(RES_W-1){1'b1}}};
    else if (dec_o.under)
      dec_o.value = {1'b1, {(RES_W-1){1'b0}}};
    else
      dec_o.value = frame_i[MSB_POS -: RES_W];
  end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adc_rd_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             sdo_i,
  output logic             cs_no,
  output logic             sck_o,
  output logic [RES_W-1:0] result_o,
  output logic [SUB_W-1:0] sub_lsb_o,
  output logic             over_o,
  output logic             under_o,
  output logic             valid_o,
  output logic             err_o
);
  rd_state_e          state_q;
  logic               run, rise, fall, full, done, clear;
  logic [FRAME_W-1:0] frame;
  frame_dec_t         dec;

  assign run   = (state_q == ST_SHIFT);
  assign clear = (state_q == ST_IDLE) && start_i;
  assign done  = run && fall && full;

  adc_sck_gen #(.HALF_DIV(HALF_DIV)) u_sck (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(run),
    .sck_o (sck_o), .rise_o(rise),   .fall_o(fall)
  );

  adc_bit_shifter #(.W(FRAME_W)) u_shift (
    .clk_i  (clk_i), .rst_ni (rst_ni), .clear_i(clear),
    .shift_i(rise),  .bit_i  (sdo_i),  .frame_o(frame), .full_o(full)
  );

  adc_frame_decode u_dec (.frame_i(frame), .dec_o(dec));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_no   <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (start_i) begin state_q <= ST_WAIT; cs_no <= 1'b0; end
        ST_WAIT:  if (!sdo_i)  state_q <= ST_SHIFT;  // end of conversion seen
        ST_SHIFT: if (done)    begin state_q <= ST_IDLE; cs_no <= 1'b1; end
        default:  begin state_q <= ST_IDLE; cs_no <= 1'b1; end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      sub_lsb_o <= '0;
      over_o    <= 1'b0;
      under_o   <= 1'b0;
      valid_o   <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      valid_o <= done && !dec.bad;
      err_o   <= done && dec.bad;
      if (done) begin
        result_o  <= dec.value;
        sub_lsb_o <= dec.sub;
        over_o    <= dec.over;
        under_o   <= dec.under;
      end
    end
  end

  AST_SCK_IDLE:       assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o); // R3
  AST_WAIT_NO_SCK:    assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> !sck_o); // R2
  AST_VALID_PULSE:    assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R9
  AST_CS_ON_VALID:    assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> cs_no); // R9
  AST_VALID_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && err_o)); // R8
  AST_RANGE_EXCL:     assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(over_o && under_o)); // R6
endmodule

// File: tb/adc_frame_reader_bench.sv
module adc_frame_reader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 2;

  logic        clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0, sdo_i = 1'b1;
  logic        cs_no, sck_o, over_o, under_o, valid_o, err_o;
  logic [23:0] result_o;
  logic [4:0]  sub_lsb_o;

  int tests = 0, fails = 0;
  int rise_cnt = 0, cyc = 0, first_rise = 0, last_rise = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge sck_o) begin
    if (rise_cnt == 0) first_rise = cyc;
    last_rise = cyc;
    rise_cnt++;
  end

  adc_frame_reader #(.HALF_DIV(HALF_DIV)) u_adc_frame_reader (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .sdo_i(sdo_i),
    .cs_no(cs_no), .sck_o(sck_o), .result_o(result_o), .sub_lsb_o(sub_lsb_o),
    .over_o(over_o), .under_o(under_o), .valid_o(valid_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_res(input logic [31:0] f);
    if (f[29] && f[28])        return 24'h7FFFFF;
    else if (!f[29] && !f[28]) return 24'h800000;
    else                       return f[28:5];
  endfunction

  task automatic run_frame(input logic [31:0] f, input int dly, input bit extra_start);
    bit good;
    good = (f[31:30] == 2'b00);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(cs_no == 1'b0, "R2 cs low", {31'd0, cs_no}, 32'd0);
    rise_cnt = 0;
    sdo_i = 1'b1;
    repeat (dly) @(negedge clk);
    chk(rise_cnt == 0, "R2 no sck before eoc", rise_cnt, 0);
    sdo_i = 1'b0;
    @(negedge clk); sdo_i = f[31];
    for (int i = 30; i >= 0; i--) begin
      @(negedge sck_o);
      sdo_i = f[i];
      if (extra_start && i == 15) begin
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
      end
      if (i == 1) chk(cs_no == 1'b0, "R9 cs held", {31'd0, cs_no}, 32'd0);
    end
    @(negedge sck_o);
    sdo_i = 1'b1;
    @(negedge clk);
    chk(rise_cnt == 32, "R3 rise count", rise_cnt, 32);
    chk(last_rise - first_rise == 31*2*HALF_DIV, "R3 sck period", last_rise - first_rise, 31*2*HALF_DIV);
    chk(cs_no == 1'b1, "R9 cs released", {31'd0, cs_no}, 32'd1);
    chk(valid_o == good, "R9 R8 valid", {31'd0, valid_o}, {31'd0, good});
    chk(err_o == !good, "R8 err", {31'd0, err_o}, {31'd0, !good});
    if (good) begin
      chk(result_o == exp_res(f), "R4 result", {8'd0, result_o}, {8'd0, exp_res(f)});
      chk(sub_lsb_o == f[4:0], "R5 sub lsb", {27'd0, sub_lsb_o}, {27'd0, f[4:0]});
      chk(over_o == (f[29] & f[28]), "R6 over", {31'd0, over_o}, {31'd0, f[29] & f[28]});
      chk(under_o == (!f[29] & !f[28]), "R7 under", {31'd0, under_o}, {31'd0, !f[29] & !f[28]});
    end
    @(negedge clk);
    chk(valid_o == 1'b0 && err_o == 1'b0, "R9 single pulse", {30'd0, valid_o, err_o}, 32'd0);
    if (extra_start) begin
      repeat (8) @(negedge clk);
      chk(cs_no == 1'b1 && rise_cnt == 32, "R10 start ignored", {31'd0, cs_no}, 32'd1);
    end
  endtask

  task automatic main_seq();
    logic [31:0] f;
    void'($urandom(32'h2484_5EED));
    #(CLK_PERIOD*2);
    chk(cs_no == 1'b1 && sck_o == 1'b0 && !valid_o && !err_o, "R1 reset",
        {28'd0, cs_no, sck_o, valid_o, err_o}, 32'h8);
    @(negedge clk); rst_ni = 1'b1;
    run_frame(32'h2000_0000, 3, 1'b0);            // zero, R4
    run_frame(32'h1FFF_FFE0 | 32'h15, 5, 1'b0);   // minus one LSB, R4 R5
    run_frame(32'h2FFF_FFFF, 2, 1'b0);            // plus full scale minus one, R4
    run_frame(32'h1000_0000, 1, 1'b0);            // minus full scale, R4
    run_frame(32'h3000_0000, 4, 1'b0);            // R6 over
    run_frame(32'h0FFF_FFFF, 4, 1'b0);            // R7 under
    run_frame(32'h8000_0000 | 32'h2ABC_DE00, 2, 1'b0); // R8 eoc set
    run_frame(32'h4000_0000 | 32'h2ABC_DE00, 2, 1'b0); // R8 dummy set
    run_frame(32'h2123_4560, 3, 1'b1);            // R10
    for (int n = 0; n < 40; n++) begin
      f = $urandom;
      f[31:30] = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
      run_frame(f, 1 + ($urandom % 20), 1'b0);
    end
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule